// File: doc/BRIEF.md
# Accumulator ALU with Program Status Flags

This block is the arithmetic core of a small 8-bit accumulator machine. It keeps three architectural registers, the accumulator, an auxiliary B register and a set of status flags (carry, auxiliary carry and overflow). Every clock edge it applies one operation to them. The operation is selected by a 5-bit opcode and takes a second operand byte where the operation needs one. All results, including two-register results such as a multiply, are written in the same edge.

Instruction fetch, decode and operand addressing live outside the block. The surrounding pipeline presents a decoded opcode and the already-fetched operand every cycle, and uses opcode 0 when it has nothing to do. The flags come out packed in a status byte: carry in bit 7, auxiliary carry in bit 6, overflow in bit 2, and zero in every other bit.

Top module: `acc_alu`

## Requirements
- R1: While rst_n is low the accumulator, B and all flags clear to zero. psw_o always carries CY in bit 7, AC in bit 6 and OV in bit 2, with bits 5..3 and 1..0 reading zero.
- R2: Opcode 3 (add) and opcode 4 (add with carry-in CY) write the 8-bit sum to the accumulator. CY is bit 8 of the zero-extended sum. AC is the carry out of the low-nibble sum. OV is set when the signed sum leaves -128..127. Opcode 3 ignores the incoming CY.
- R3: Opcode 5 (subtract with borrow) writes ACC - operand - CY. CY is set when that unsigned difference is negative, AC when the low-nibble difference borrows, and OV when the signed difference leaves -128..127.
- R4: Opcodes 1 (accumulator = operand), 2 (B = operand), 6 (AND), 7 (OR), 8 (XOR), 9 (increment), 10 (decrement), 11 (complement), 12 (clear) and 13 (swap nibbles ACC[3:0] with ACC[7:4]) produce their 8-bit result and leave CY, AC and OV unchanged.
- R5: Opcode 14 rotates the accumulator left and opcode 15 rotates it right, with the flags untouched. Opcode 16 rotates left and opcode 17 rotates right through the 9-bit ring formed by the accumulator and CY.
- R6: Opcode 18 (decimal adjust) first adds 6 when AC is set or the low nibble is above 9. It then adds 0x60 when that step carried out of bit 7, when CY is set, or when the high nibble of the intermediate value is above 9. The new CY is the OR of the old CY and both carries. AC and OV are unchanged.
- R7: Opcode 19 multiplies ACC by B as unsigned values: the low product byte goes to the accumulator and the high byte to B. CY is cleared, OV is set exactly when the high byte is non-zero, and AC is unchanged.
- R8: Opcode 20 with B non-zero writes the unsigned quotient ACC / B to the accumulator and the remainder to B, and clears CY and OV.
- R9: Opcode 20 with B zero writes 0xFF to the accumulator, copies the old accumulator into B, clears CY and sets OV.
- R10: Opcode 21 (compare) sets CY when ACC is below the operand (unsigned) and clears it otherwise. The accumulator, B, AC and OV stay unchanged.
- R11: Opcode 22 sets CY and opcode 23 clears it, with nothing else changed. Opcode 0 and opcodes 24..31 change no register.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock; all state updates on the rising edge |
| rst_n | input | 1 | Active-low synchronous reset |
| op_code | input | 5 | Operation applied at the next rising edge |
| operand | input | 8 | Second operand byte |
| acc_o | output | 8 | Accumulator register |
| b_o | output | 8 | B register |
| psw_o | output | 8 | Status byte: CY bit 7, AC bit 6, OV bit 2 |

## Verification
The properties in the top module watch every cycle for the relations that tie one cycle's registers to the next. These cover the product spread over B and the accumulator, the quotient and remainder identity, the divide-by-zero outcome, the carry-only effect of compare, the nine-bit rotate ring, flags held across logical operations, decimal adjust never dropping a set carry, and idle opcodes holding all state. The exact values of the sum, the difference, the nibble carries and the signed overflow cannot be stated cheaply as a property. The same holds for the digits corrected by decimal adjust and the reset contents. Only the bench's sweeps show these, comparing every register after every operation with an arithmetic model.

// File: rtl/acc_alu_pkg.sv
package acc_alu_pkg;

   localparam int OPC_W      = 5;
   localparam int PSW_W      = 8;
   localparam int PSW_CY_BIT = 7;
   localparam int PSW_AC_BIT = 6;
   localparam int PSW_OV_BIT = 2;

   typedef enum logic [OPC_W-1:0] {
      OP_NOP  = 5'd0,
      OP_LDA  = 5'd1,
      OP_LDB  = 5'd2,
      OP_ADD  = 5'd3,
      OP_ADDC = 5'd4,
      OP_SUBB = 5'd5,
      OP_AND  = 5'd6,
      OP_OR   = 5'd7,
      OP_XOR  = 5'd8,
      OP_INC  = 5'd9,
      OP_DEC  = 5'd10,
      OP_CPL  = 5'd11,
      OP_CLR  = 5'd12,
      OP_SWAP = 5'd13,
      OP_RL   = 5'd14,
      OP_RR   = 5'd15,
      OP_RLC  = 5'd16,
      OP_RRC  = 5'd17,
      OP_DA   = 5'd18,
      OP_MUL  = 5'd19,
      OP_DIV  = 5'd20,
      OP_CMP  = 5'd21,
      OP_SETC = 5'd22,
      OP_CLRC = 5'd23
   } alu_op_e;

   typedef struct packed {
      logic cy;
      logic ac;
      logic ov;
   } alu_flags_t;

endpackage

// File: rtl/acc_alu_addsub.sv
module acc_alu_addsub #(
   parameter int DATA_W = 8,
   parameter int NIB_W  = 4
) (
   input  logic [DATA_W-1:0] a,
   input  logic [DATA_W-1:0] b,
   input  logic              cin,
   input  logic              sub,
   output logic [DATA_W-1:0] res,
   output logic              cy,
   output logic              ac,
   output logic              ov
);

   localparam int EXT_W = DATA_W + 1;
   localparam int MSB   = DATA_W - 1;

   if (NIB_W < 1 || NIB_W >= DATA_W) begin : g_bad_nib
      $error("acc_alu_addsub: NIB_W must lie between 1 and DATA_W-1");
   end

   logic [EXT_W-1:0] wide;
   logic [EXT_W-1:0] cin_ext;

   assign cin_ext = {{DATA_W{1'b0}}, cin};

   always_comb begin
      if (sub) begin
         wide = {1'b0, a} - {1'b0, b} - cin_ext;
      end else begin
         wide = {1'b0, a} + {1'b0, b} + cin_ext;
      end
   end

   assign res = wide[DATA_W-1:0];
   // Carry or borrow out of the top bit.
   assign cy  = wide[DATA_W];
   // Carry (or borrow) into a bit is recovered from that bit's sum and inputs.
   assign ac  = wide[NIB_W] ^ a[NIB_W] ^ b[NIB_W];
   // Signed overflow: operand signs that should agree with the result do not.
   assign ov  = sub ? ((a[MSB] != b[MSB]) && (wide[MSB] != a[MSB]))
                    : ((a[MSB] == b[MSB]) && (wide[MSB] != a[MSB]));

endmodule

// File: rtl/acc_alu_decadj.sv
module acc_alu_decadj #(
   parameter int DATA_W = 8
) (
   input  logic [DATA_W-1:0] acc,
   input  logic              ac_in,
   input  logic              cy_in,
   output logic [DATA_W-1:0] res,
   output logic              cy_out
);

   localparam int EXT_W = DATA_W + 1;
   localparam logic [EXT_W-1:0] LO_FIX = EXT_W'(6);
   localparam logic [EXT_W-1:0] HI_FIX = EXT_W'(8'h60);

   if (DATA_W < 8) begin : g_bad_w
      $error("acc_alu_decadj: DATA_W must be at least 8");
   end

   logic             fix_lo;
   logic             fix_hi;
   logic [EXT_W-1:0] stage1;
   logic [EXT_W-1:0] stage2;

   always_comb begin
      fix_lo = ac_in || (acc[3:0] > 4'd9);
      stage1 = {1'b0, acc} + (fix_lo ? LO_FIX : '0);
      fix_hi = stage1[DATA_W] || cy_in || (stage1[7:4] > 4'd9);
      stage2 = stage1 + (fix_hi ? HI_FIX : '0);
   end

   assign res    = stage2[DATA_W-1:0];
   assign cy_out = cy_in | stage1[DATA_W] | stage2[DATA_W];

endmodule

// File: rtl/acc_alu_mul.sv
module acc_alu_mul #(
   parameter int DATA_W    = 8,
   parameter int MUL_STYLE = 1
) (
   input  logic [DATA_W-1:0]   a,
   input  logic [DATA_W-1:0]   b,
   output logic [2*DATA_W-1:0] prod
);

   localparam int PROD_W = 2 * DATA_W;

   if (MUL_STYLE == 0) begin : g_mul_op
      assign prod = PROD_W'(a) * PROD_W'(b);
   end else if (MUL_STYLE == 1) begin : g_mul_shift_add
      logic [PROD_W-1:0] part [DATA_W+1];
      assign part[0] = '0;
      for (genvar gi = 0; gi < DATA_W; gi++) begin : g_row
         assign part[gi+1] = part[gi] + (b[gi] ? (PROD_W'(a) << gi) : '0);
      end
      assign prod = part[DATA_W];
   end else begin : g_bad_style
      $error("acc_alu_mul: MUL_STYLE must be 0 or 1");
   end

endmodule

// File: rtl/acc_alu_div.sv
module acc_alu_div #(
   parameter int DATA_W    = 8,
   parameter int DIV_STYLE = 1
) (
   input  logic [DATA_W-1:0] a,
   input  logic [DATA_W-1:0] b,
   output logic [DATA_W-1:0] quo,
   output logic [DATA_W-1:0] rem,
   output logic              dz
);

   logic [DATA_W-1:0] q_raw;
   logic [DATA_W-1:0] r_raw;

   if (DIV_STYLE == 0) begin : g_div_op
      assign q_raw = a / b;
      assign r_raw = a % b;
   end else if (DIV_STYLE == 1) begin : g_div_restoring
      logic [DATA_W-1:0] part [DATA_W+1];
      assign part[0] = '0;
      for (genvar gi = 0; gi < DATA_W; gi++) begin : g_step
         localparam int K = DATA_W - 1 - gi;
         logic [DATA_W:0]   shifted;
         logic [DATA_W-1:0] diff;
         logic              fits;
         assign shifted     = {part[gi], a[K]};
         assign fits        = shifted >= {1'b0, b};
         assign diff        = shifted[DATA_W-1:0] - b;
         assign q_raw[K]    = fits;
         assign part[gi+1]  = fits ? diff : shifted[DATA_W-1:0];
      end
      assign r_raw = part[DATA_W];
   end else begin : g_bad_style
      $error("acc_alu_div: DIV_STYLE must be 0 or 1");
   end

   // Zero divisor: all-ones quotient, dividend kept as remainder.
   assign dz  = (b == '0);
   assign quo = dz ? '1 : q_raw;
   assign rem = dz ? a  : r_raw;

endmodule

// File: rtl/acc_alu.sv
module acc_alu
   import acc_alu_pkg::*;
#(
   parameter int DATA_W    = 8,
   parameter int MUL_STYLE = 1,
   parameter int DIV_STYLE = 1
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic [OPC_W-1:0]  op_code,
   input  logic [DATA_W-1:0] operand,
   output logic [DATA_W-1:0] acc_o,
   output logic [DATA_W-1:0] b_o,
   output logic [PSW_W-1:0]  psw_o
);

   localparam int PROD_W = 2 * DATA_W;
   localparam int HALF_W = DATA_W / 2;

   if (DATA_W < 8 || (DATA_W % 4) != 0) begin : g_bad_width
      $error("acc_alu: DATA_W must be a multiple of 4 and at least 8");
   end

   alu_op_e           op;
   logic [DATA_W-1:0] acc_q, acc_d;
   logic [DATA_W-1:0] b_q, b_d;
   alu_flags_t        flg_q, flg_d;

   assign op = alu_op_e'(op_code);

   // Shared adder: add, add-with-carry, subtract-with-borrow and compare.
   logic              as_sub, as_cin;
   logic [DATA_W-1:0] as_res;
   logic              as_cy, as_ac, as_ov;

   assign as_sub = (op == OP_SUBB) || (op == OP_CMP);
   assign as_cin = ((op == OP_ADDC) || (op == OP_SUBB)) && flg_q.cy;

   acc_alu_addsub #(.DATA_W(DATA_W), .NIB_W(4)) u_addsub (
      .a   (acc_q),
      .b   (operand),
      .cin (as_cin),
      .sub (as_sub),
      .res (as_res),
      .cy  (as_cy),
      .ac  (as_ac),
      .ov  (as_ov)
   );

   logic [PROD_W-1:0] prod;

   acc_alu_mul #(.DATA_W(DATA_W), .MUL_STYLE(MUL_STYLE)) u_mul (
      .a    (acc_q),
      .b    (b_q),
      .prod (prod)
   );

   logic [DATA_W-1:0] quo, rem;
   logic              div_zero;

   acc_alu_div #(.DATA_W(DATA_W), .DIV_STYLE(DIV_STYLE)) u_div (
      .a   (acc_q),
      .b   (b_q),
      .quo (quo),
      .rem (rem),
      .dz  (div_zero)
   );

   logic [DATA_W-1:0] da_res;
   logic              da_cy;

   acc_alu_decadj #(.DATA_W(DATA_W)) u_decadj (
      .acc    (acc_q),
      .ac_in  (flg_q.ac),
      .cy_in  (flg_q.cy),
      .res    (da_res),
      .cy_out (da_cy)
   );

   always_comb begin
      acc_d = acc_q;
      b_d   = b_q;
      flg_d = flg_q;
      case (op)
         OP_LDA:  acc_d = operand;
         OP_LDB:  b_d   = operand;
         OP_ADD, OP_ADDC, OP_SUBB: begin
            acc_d    = as_res;
            flg_d.cy = as_cy;
            flg_d.ac = as_ac;
            flg_d.ov = as_ov;
         end
         OP_AND:  acc_d = acc_q & operand;
         OP_OR:   acc_d = acc_q | operand;
         OP_XOR:  acc_d = acc_q ^ operand;
         OP_INC:  acc_d = acc_q + 1'b1;
         OP_DEC:  acc_d = acc_q - 1'b1;
         OP_CPL:  acc_d = ~acc_q;
         OP_CLR:  acc_d = '0;
         OP_SWAP: acc_d = {acc_q[HALF_W-1:0], acc_q[DATA_W-1:HALF_W]};
         OP_RL:   acc_d = {acc_q[DATA_W-2:0], acc_q[DATA_W-1]};
         OP_RR:   acc_d = {acc_q[0], acc_q[DATA_W-1:1]};
         OP_RLC: begin
            acc_d    = {acc_q[DATA_W-2:0], flg_q.cy};
            flg_d.cy = acc_q[DATA_W-1];
         end
         OP_RRC: begin
            acc_d    = {flg_q.cy, acc_q[DATA_W-1:1]};
            flg_d.cy = acc_q[0];
         end
         OP_DA: begin
            acc_d    = da_res;
            flg_d.cy = da_cy;
         end
         OP_MUL: begin
            acc_d    = prod[DATA_W-1:0];
            b_d      = prod[PROD_W-1:DATA_W];
            flg_d.cy = 1'b0;
            flg_d.ov = |prod[PROD_W-1:DATA_W];
         end
         OP_DIV: begin
            acc_d    = quo;
            b_d      = rem;
            flg_d.cy = 1'b0;
            flg_d.ov = div_zero;
         end
         OP_CMP:  flg_d.cy = as_cy;
         OP_SETC: flg_d.cy = 1'b1;
         OP_CLRC: flg_d.cy = 1'b0;
         default: ;
      endcase
   end

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         acc_q <= '0;
         b_q   <= '0;
         flg_q <= '0;
      end else begin
         acc_q <= acc_d;
         b_q   <= b_d;
         flg_q <= flg_d;
      end
   end

   assign acc_o = acc_q;
   assign b_o   = b_q;

   always_comb begin
      psw_o             = '0;
      psw_o[PSW_CY_BIT] = flg_q.cy;
      psw_o[PSW_AC_BIT] = flg_q.ac;
      psw_o[PSW_OV_BIT] = flg_q.ov;
   end

   // ---------------------------------------------------------------- checks

   p_flags_hold_r4: assert property (@(posedge clk) disable iff (!rst_n)
      (op inside {OP_LDA, OP_LDB, OP_AND, OP_OR, OP_XOR, OP_INC, OP_DEC,
                  OP_CPL, OP_CLR, OP_SWAP, OP_RL, OP_RR})
      |=> (flg_q == $past(flg_q)));

   p_rlc_ring_r5: assert property (@(posedge clk) disable iff (!rst_n)
      (op == OP_RLC)
      |=> (({flg_q.cy, acc_q} == {$past(acc_q), $past(flg_q.cy)})
           && $stable(b_q)));

   p_da_cy_sticky_r6: assert property (@(posedge clk) disable iff (!rst_n)
      (op == OP_DA && flg_q.cy) |=> flg_q.cy);

   p_mul_product_r7: assert property (@(posedge clk) disable iff (!rst_n)
      (op == OP_MUL)
      |=> (({b_q, acc_q} == PROD_W'($past(acc_q)) * PROD_W'($past(b_q)))
           && !flg_q.cy && (flg_q.ov == (b_q != '0))));

   p_div_identity_r8: assert property (@(posedge clk) disable iff (!rst_n)
      (op == OP_DIV && b_q != '0)
      |=> ((PROD_W'(acc_q) * PROD_W'($past(b_q)) + PROD_W'(b_q)
            == PROD_W'($past(acc_q)))
           && (b_q < $past(b_q)) && !flg_q.cy && !flg_q.ov));

   p_div_zero_r9: assert property (@(posedge clk) disable iff (!rst_n)
      (op == OP_DIV && b_q == '0)
      |=> ((acc_q == '1) && (b_q == $past(acc_q)) && flg_q.ov && !flg_q.cy));

   p_cmp_only_cy_r10: assert property (@(posedge clk) disable iff (!rst_n)
      (op == OP_CMP)
      |=> ($stable(acc_q) && $stable(b_q) && $stable(flg_q.ac)
           && $stable(flg_q.ov) && (flg_q.cy == ($past(acc_q) < $past(operand)))));

   p_idle_hold_r11: assert property (@(posedge clk) disable iff (!rst_n)
      ((op_code == 5'd0) || (op_code >= 5'd24))
      |=> ($stable(acc_q) && $stable(b_q) && $stable(flg_q)));

endmodule

// File: tb/acc_alu_bench.sv
module acc_alu_bench;

   localparam int CLK_PERIOD = 10;
   localparam int WATCHDOG   = 199000;

   localparam int C_NOP = 0,  C_LDA = 1,  C_LDB = 2,  C_ADD = 3,  C_ADDC = 4;
   localparam int C_SUBB = 5, C_AND = 6,  C_OR = 7,   C_XOR = 8,  C_INC = 9;
   localparam int C_DEC = 10, C_CPL = 11, C_CLR = 12, C_SWAP = 13, C_RL = 14;
   localparam int C_RR = 15,  C_RLC = 16, C_RRC = 17, C_DA = 18,  C_MUL = 19;
   localparam int C_DIV = 20, C_CMP = 21, C_SETC = 22, C_CLRC = 23;

   logic       clk;
   logic       rst_n;
   logic [4:0] op_code;
   logic [7:0] operand;
   logic [7:0] acc_o, b_o, psw_o;

   int n_checks = 0;
   int n_err    = 0;
   bit finished = 0;

   int m_acc, m_b, m_cy, m_ac, m_ov;

   acc_alu u_acc_alu (
      .clk     (clk),
      .rst_n   (rst_n),
      .op_code (op_code),
      .operand (operand),
      .acc_o   (acc_o),
      .b_o     (b_o),
      .psw_o   (psw_o)
   );

   initial clk = 1'b0;
   always #(CLK_PERIOD/2) clk = ~clk;

   function automatic int to_signed8(input int v);
      return (v > 127) ? v - 256 : v;
   endfunction

   task automatic model_step(input int code, input int src);
      int u, s, p;
      case (code)
         C_LDA:  m_acc = src;
         C_LDB:  m_b   = src;
         C_ADD, C_ADDC: begin
            int cin;
            cin  = (code == C_ADDC) ? m_cy : 0;
            u    = m_acc + src + cin;
            s    = to_signed8(m_acc) + to_signed8(src) + cin;
            m_ac = ((m_acc % 16) + (src % 16) + cin > 15) ? 1 : 0;
            m_cy = (u > 255) ? 1 : 0;
            m_ov = (s > 127 || s < -128) ? 1 : 0;
            m_acc = u % 256;
         end
         C_SUBB: begin
            u    = m_acc - src - m_cy;
            s    = to_signed8(m_acc) - to_signed8(src) - m_cy;
            m_ac = ((m_acc % 16) < (src % 16) + m_cy) ? 1 : 0;
            m_ov = (s > 127 || s < -128) ? 1 : 0;
            m_cy = (u < 0) ? 1 : 0;
            m_acc = (u + 512) % 256;
         end
         C_AND:  m_acc = m_acc & src;
         C_OR:   m_acc = m_acc | src;
         C_XOR:  m_acc = m_acc ^ src;
         C_INC:  m_acc = (m_acc + 1) % 256;
         C_DEC:  m_acc = (m_acc + 255) % 256;
         C_CPL:  m_acc = 255 - m_acc;
         C_CLR:  m_acc = 0;
         C_SWAP: m_acc = (m_acc % 16) * 16 + m_acc / 16;
         C_RL:   m_acc = ((m_acc * 2) % 256) + m_acc / 128;
         C_RR:   m_acc = m_acc / 2 + (m_acc % 2) * 128;
         C_RLC: begin
            p = m_acc / 128;
            m_acc = ((m_acc * 2) % 256) + m_cy;
            m_cy = p;
         end
         C_RRC: begin
            p = m_acc % 2;
            m_acc = m_acc / 2 + m_cy * 128;
            m_cy = p;
         end
         C_DA: begin
            int v1, v2, c1, c2;
            v1 = m_acc;
            if (m_ac == 1 || (m_acc % 16) > 9) v1 = v1 + 6;
            c1 = (v1 >= 256) ? 1 : 0;
            v2 = v1;
            if (c1 == 1 || m_cy == 1 || ((v1 / 16) % 16) > 9) v2 = v2 + 96;
            c2 = ((v2 / 256) % 2 == 1) ? 1 : 0;
            m_cy = (m_cy | c1 | c2);
            m_acc = v2 % 256;
         end
         C_MUL: begin
            p = m_acc * m_b;
            m_acc = p % 256;
            m_b = p / 256;
            m_cy = 0;
            m_ov = (m_b != 0) ? 1 : 0;
         end
         C_DIV: begin
            m_cy = 0;
            if (m_b == 0) begin
               m_b = m_acc;
               m_acc = 255;
               m_ov = 1;
            end else begin
               p = m_acc;
               m_acc = p / m_b;
               m_b = p % m_b;
               m_ov = 0;
            end
         end
         C_CMP:  m_cy = (m_acc < src) ? 1 : 0;
         C_SETC: m_cy = 1;
         C_CLRC: m_cy = 0;
         default: ;
      endcase
   endtask

   task automatic check_state(input string tag);
      logic [7:0] exp_psw;
      exp_psw = {m_cy[0], m_ac[0], 3'b000, m_ov[0], 2'b00};
      n_checks++;
      if (acc_o !== m_acc[7:0] || b_o !== m_b[7:0] || psw_o !== exp_psw) begin
         n_err++;
         $display("FAIL %s: acc=%02h b=%02h psw=%02h expected acc=%02h b=%02h psw=%02h",
                  tag, acc_o, b_o, psw_o, m_acc[7:0], m_b[7:0], exp_psw);
      end
   endtask

   // Called at a falling edge; drives, lets one rising edge pass, checks.
   task automatic run_op(input int code, input int src, input string tag);
      op_code = code[4:0];
      operand = src[7:0];
      model_step(code, src);
      @(negedge clk);
      check_state(tag);
   endtask

   task automatic set_cy(input int c);
      run_op((c != 0) ? C_SETC : C_CLRC, 0, "R11");
   endtask

   initial begin
      rst_n   = 1'b0;
      op_code = 5'd0;
      operand = 8'h00;
      m_acc = 0; m_b = 0; m_cy = 0; m_ac = 0; m_ov = 0;
      // Load something before reset so the clear is observable.
      repeat (3) @(negedge clk);
      check_state("R1");
      rst_n = 1'b1;
      run_op(C_LDA, 8'hA5, "R4");
      run_op(C_LDB, 8'h3C, "R4");
      run_op(C_SETC, 0, "R11");
      op_code = 5'd0;
      rst_n = 1'b0;
      m_acc = 0; m_b = 0; m_cy = 0; m_ac = 0; m_ov = 0;
      @(negedge clk);
      check_state("R1");
      rst_n = 1'b1;

      // R2 / R3: add, add with carry, subtract with borrow.
      for (int a = 0; a < 256; a += 3) begin
         for (int k = 0; k < 16; k++) begin
            for (int c = 0; c < 2; c++) begin
               run_op(C_LDA, a, "R4");
               set_cy(c);
               run_op(C_ADD, k * 17, "R2");
               run_op(C_LDA, a, "R4");
               set_cy(c);
               run_op(C_ADDC, k * 17, "R2");
               run_op(C_LDA, a, "R4");
               set_cy(c);
               run_op(C_SUBB, k * 17, "R3");
            end
         end
      end

      // R4: logical and unary operations keep the flags.
      for (int a = 0; a < 256; a++) begin
         run_op(C_LDA, 8'h7F, "R4");
         run_op(C_ADD, a, "R2");          // leaves a varied flag pattern
         run_op(C_LDA, a, "R4");
         run_op(C_AND, (a * 7 + 13) % 256, "R4");
         run_op(C_OR, (a * 5 + 3) % 256, "R4");
         run_op(C_XOR, (a * 11 + 1) % 256, "R4");
         run_op(C_INC, 0, "R4");
         run_op(C_DEC, 0, "R4");
         run_op(C_DEC, 0, "R4");
         run_op(C_CPL, 0, "R4");
         run_op(C_SWAP, 0, "R4");
         run_op(C_CLR, 0, "R4");
      end

      // R5: rotates.
      for (int a = 0; a < 256; a++) begin
         for (int c = 0; c < 2; c++) begin
            run_op(C_LDA, a, "R4");
            set_cy(c);
            run_op(C_RLC, 0, "R5");
            run_op(C_LDA, a, "R4");
            set_cy(c);
            run_op(C_RRC, 0, "R5");
            run_op(C_LDA, a, "R4");
            run_op(C_RL, 0, "R5");
            run_op(C_RR, 0, "R5");
            run_op(C_RR, 0, "R5");
         end
      end

      // R6: decimal adjust after additions of varied digits.
      for (int x = 0; x < 256; x++) begin
         for (int j = 0; j < 6; j++) begin
            int y;
            y = (j == 0) ? 8'h00 : (j == 1) ? 8'h09 : (j == 2) ? 8'h19 :
                (j == 3) ? 8'h55 : (j == 4) ? 8'h99 : 8'h08;
            for (int c = 0; c < 2; c++) begin
               run_op(C_LDA, x, "R4");
               set_cy(c);
               run_op(C_ADDC, y, "R2");
               run_op(C_DA, 0, "R6");
            end
         end
      end

      // R7: multiply.
      for (int a = 0; a < 256; a++) begin
         for (int k = 0; k < 16; k++) begin
            run_op(C_LDA, a, "R4");
            run_op(C_LDB, k * 17, "R4");
            run_op(C_MUL, 0, "R7");
         end
      end

      // R8 / R9: divide, including a zero divisor.
      for (int a = 0; a < 256; a++) begin
         for (int k = 0; k < 32; k++) begin
            int d;
            d = (k < 16) ? k * 17 : k - 15;
            run_op(C_LDA, a, "R4");
            run_op(C_LDB, d, "R4");
            set_cy(k % 2);
            run_op(C_DIV, 0, (d == 0) ? "R9" : "R8");
         end
      end

      // R10: compare sets only the carry.
      for (int a = 0; a < 256; a++) begin
         run_op(C_LDA, 8'h7F, "R4");
         run_op(C_ADD, 8'h01, "R2");      // AC and OV set before compare
         run_op(C_LDA, a, "R4");
         run_op(C_LDB, 8'h5A, "R4");
         for (int k = 0; k < 16; k++) begin
            set_cy(k % 2);
            run_op(C_CMP, k * 17, "R10");
         end
         run_op(C_CMP, a, "R10");
      end

      // R11: idle and unused opcodes change nothing.
      run_op(C_LDA, 8'hC3, "R4");
      run_op(C_LDB, 8'h81, "R4");
      run_op(C_ADD, 8'h80, "R2");
      for (int code = 24; code < 32; code++) begin
         run_op(code, 8'hFF, "R11");
         run_op(C_NOP, 8'h55, "R11");
      end
      set_cy(1);
      run_op(C_NOP, 0, "R11");
      set_cy(0);

      op_code = 5'd0;
      finished = 1;
      $display("  CHECKS %0d ERRORS %0d", n_checks, n_err);
      $finish;
   end

   initial begin
      repeat (WATCHDOG) @(posedge clk);
      if (!finished) begin
         n_checks++;
         n_err++;
         $display("FAIL watchdog (R1..): actual=still running expected=done");
         $display("  CHECKS %0d ERRORS %0d", n_checks, n_err);
         $finish;
      end
   end

endmodule